// File: doc/BRIEF.md
# Overlay Layer Window Blender with Palette

This block is one per-pixel composition stage of a display pipeline. For every active-area pixel it receives the pixel's coordinates, one layer pixel and the side-band sync flags. The layer pixel is either a 32-bit colour with alpha in the top byte or an 8-bit palette index. The block emits one 24-bit RGB pixel per clock, two clocks later. When the layer is enabled and the coordinate lies inside the programmed layer window, the layer colour is mixed over a programmable background colour. Otherwise the background colour goes out unchanged.

All configuration reaches the block through one register write port made of a select code and a 32-bit data word. This port loads the control bits, the background colour, the constant alpha, the blend-factor code and the two window spans. It also loads the 256-entry palette, one entry per write: each write word carries both the entry number and the 24-bit colour. Palette mode replaces the pixel colour with the palette entry and treats the pixel as fully opaque. The blend weight of the layer is either the product of pixel alpha and constant alpha, or the constant alpha alone. The background gets the remainder of 255.

Top module: `ovl_blend_top`

## Requirements
- R1: A pixel presented with `pix_valid` high appears on the outputs exactly 2 clock cycles later with `out_valid` high. `out_hs` and `out_vs` are `pix_hs` and `pix_vs` delayed by the same 2 cycles, and results leave in the order the pixels arrived.
- R2: While `out_valid` is low, `out_rgb` is 0. After reset, `out_valid` is low.
- R3: The window spans are written with select 4 (horizontal) and select 5 (vertical). In each word, bits [15:0] hold the first coordinate and bits [31:16] hold the width. A pixel is inside when first <= coordinate <= first + width - 1 on both axes. A width of 0 makes the window empty. Pixels outside the window output the background colour. Both spans reset to width 0.
- R4: Control register, select 0: bit 0 enables the layer. While bit 0 is 0, every valid pixel outputs the background colour. The control register resets to 0.
- R5: Background colour, select 1: red is in bits [23:16], green in [15:8] and blue in [7:0]. `out_rgb` uses the same layout. The background resets to black, 0x000000.
- R6: Blend code 7, select 3, bits [2:0]: the layer weight is f = (pa*ca + 127)/255, where pa is the pixel alpha and ca is the constant alpha (select 2, bits [7:0]). Each output channel is (L*f + B*(255-f) + 127)/255, with integer division.
- R7: For any blend code other than 7 (nominally 5), the layer weight is f = ca and pixel alpha is ignored. A constant alpha of 0 then outputs the background colour.
- R8: Control bit 4 selects palette mode. Bits [7:0] of `pix_data` index the palette, the entry's colour replaces the pixel colour, and pa is taken as 255.
- R9: A write with select 6 loads palette entry `cfg_wdata[31:24]` with colour `cfg_wdata[23:16]` red, `[15:8]` green and `[7:0]` blue.
- R10: Control bit 8 marks the pixel format as having no alpha: pa is taken as 255 whatever `pix_data[31:24]` holds.
- R11: A palette lookup made in the same cycle as a write to the same entry returns the entry's previous colour. The next lookup returns the new colour.
- R12: Constant alpha resets to 0xFF and the blend code resets to 7. A configuration write takes effect for pixels presented from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code (0 control, 1 background, 2 constant alpha, 3 blend code, 4 horizontal span, 5 vertical span, 6 palette entry) |
| cfg_wdata | input | 32 | Configuration write data |
| pix_valid | input | 1 | Input pixel is an active-area pixel |
| pix_hs | input | 1 | Horizontal sync side-band in |
| pix_vs | input | 1 | Vertical sync side-band in |
| pix_x | input | 16 | Active-area column of the pixel |
| pix_y | input | 16 | Active-area row of the pixel |
| pix_data | input | 32 | Layer pixel: alpha [31:24], RGB [23:0], or palette index [7:0] |
| out_valid | output | 1 | Output pixel valid |
| out_hs | output | 1 | Horizontal sync side-band out |
| out_vs | output | 1 | Vertical sync side-band out |
| out_rgb | output | 24 | Composed pixel, red [23:16], green [15:8], blue [7:0] |

## Verification
Two functions can land in the same cycle: a palette write and a palette lookup of the same entry. To provoke the overlap, the bench first loads a known colour into one entry. It then presents an index pixel that names this entry in the very cycle in which a second write replaces the entry's colour. The scoreboard expects the old colour for that pixel and the new colour for the pixel that follows. Configuration writes that land while earlier pixels are still in the pipeline are judged the same way: each in-flight pixel keeps the settings it was sampled with.

// File: rtl/ovl_blend_pkg.sv
// Shared constants, types and arithmetic helpers for the overlay blender.
// Assumes 8-bit colour channels and 16-bit active-area coordinates.
package ovl_blend_pkg;

    localparam int COORD_W   = 16;
    localparam int CH_W      = 8;
    localparam int NUM_CH    = 3;
    localparam int RGB_W     = CH_W * NUM_CH;
    localparam int PAL_DEPTH = 256;
    localparam int PAL_AW    = $clog2(PAL_DEPTH);
    localparam int ACC_W     = 2 * CH_W + 1;

    // register select codes on the configuration port
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_BG    = 3'd1,
        SEL_ALPHA = 3'd2,
        SEL_BLEND = 3'd3,
        SEL_WIN_X = 3'd4,
        SEL_WIN_Y = 3'd5,
        SEL_PAL   = 3'd6
    } cfg_sel_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PAL_BIT = 4;
    localparam int CTRL_OPQ_BIT = 8;

    localparam logic [2:0] BLEND_PIX_X_CONST = 3'd7;

    // one window axis: first coordinate, inclusive last coordinate, non-empty flag
    typedef struct packed {
        logic [COORD_W-1:0] first;
        logic [COORD_W:0]   last;
        logic               nonempty;
    } span_t;

    // rounded-down quotient by 255 of a value known to be below 256*255
    function automatic logic [CH_W-1:0] div255(input logic [ACC_W-1:0] v);
        return CH_W'(v / ACC_W'(255));
    endfunction

endpackage

// File: rtl/ovl_cfg_regs.sv
// Configuration register file of the overlay blender.
// Decodes writes on the select/data port, keeps control, colour, alpha,
// blend code and window spans, and forwards palette writes unregistered.
// Assumes one write per cycle; a write is visible from the next cycle.
module ovl_cfg_regs
    import ovl_blend_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          sel,
    input  logic [31:0]         wdata,
    output logic                layer_en,
    output logic                pal_mode,
    output logic                opaque,
    output logic [RGB_W-1:0]    bg_color,
    output logic [CH_W-1:0]     const_alpha,
    output logic [2:0]          blend_code,
    output span_t               win_x,
    output span_t               win_y,
    output logic                pal_we,
    output logic [PAL_AW-1:0]   pal_waddr,
    output logic [RGB_W-1:0]    pal_wdata
);

    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(sel);

    // convert a first/width word into an inclusive span
    function automatic span_t make_span(input logic [31:0] w);
        span_t s;
        s.first    = w[COORD_W-1:0];
        s.last     = {1'b0, w[COORD_W-1:0]} + {1'b0, w[16 +: COORD_W]} - (COORD_W+1)'(1);
        s.nonempty = (w[16 +: COORD_W] != '0);
        return s;
    endfunction

    // register writes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layer_en    <= 1'b0;
            pal_mode    <= 1'b0;
            opaque      <= 1'b0;
            bg_color    <= '0;
            const_alpha <= '1;
            blend_code  <= BLEND_PIX_X_CONST;
            win_x       <= '0;
            win_y       <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_CTRL: begin
                    layer_en <= wdata[CTRL_EN_BIT];
                    pal_mode <= wdata[CTRL_PAL_BIT];
                    opaque   <= wdata[CTRL_OPQ_BIT];
                end
                SEL_BG:    bg_color    <= wdata[RGB_W-1:0];
                SEL_ALPHA: const_alpha <= wdata[CH_W-1:0];
                SEL_BLEND: blend_code  <= wdata[2:0];
                SEL_WIN_X: win_x       <= make_span(wdata);
                SEL_WIN_Y: win_y       <= make_span(wdata);
                default: ;
            endcase
        end
    end

    // palette writes pass straight to the table
    always_comb begin
        pal_we    = we && (sel_e == SEL_PAL);
        pal_waddr = wdata[31:24];
        pal_wdata = wdata[RGB_W-1:0];
    end

endmodule

// File: rtl/ovl_palette.sv
// Colour lookup table: one write port, one registered read port.
// A read of an entry written at the same edge returns the old contents.
// Assumes contents need no reset; entries are loaded before use.
module ovl_palette #(
    parameter  int DEPTH = 256,
    parameter  int DW    = 24,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // table update and read-before-write lookup
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/ovl_mixer.sv
// Second pipeline stage: per-channel rounded mix of layer over background,
// background bypass outside the window, zero while invalid.
// Assumes the layer weight has been computed by the first stage.
module ovl_mixer
    import ovl_blend_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic             s1_hs,
    input  logic             s1_vs,
    input  logic             s1_hit,
    input  logic [RGB_W-1:0] s1_layer,
    input  logic [RGB_W-1:0] s1_bg,
    input  logic [CH_W-1:0]  s1_f1,
    output logic             out_valid,
    output logic             out_hs,
    output logic             out_vs,
    output logic [RGB_W-1:0] out_rgb
);

    logic [RGB_W-1:0] mixed;
    logic [CH_W-1:0]  f2;

    assign f2 = CH_W'(255) - s1_f1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [ACC_W-1:0] acc;
        // weighted sum of one channel with rounding offset
        always_comb begin
            acc = ACC_W'(s1_layer[ch*CH_W +: CH_W]) * ACC_W'(s1_f1)
                + ACC_W'(s1_bg[ch*CH_W +: CH_W]) * ACC_W'(f2)
                + ACC_W'(127);
            mixed[ch*CH_W +: CH_W] = div255(acc);
        end
    end

    // output register with side-band alignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hs    <= 1'b0;
            out_vs    <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_hs    <= s1_hs;
            out_vs    <= s1_vs;
            out_rgb   <= !s1_valid ? '0 : (s1_hit ? mixed : s1_bg);
        end
    end

endmodule

// File: rtl/ovl_blend_top.sv
// Overlay layer blender: window test, palette expansion and alpha mix of
// one layer over a background colour, two clock cycles of latency.
// Stage 1 samples the pixel with the current configuration; stage 2 mixes.
// Assumes coordinates are active-area relative and one pixel per clock.
module ovl_blend_top
    import ovl_blend_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               pix_valid,
    input  logic               pix_hs,
    input  logic               pix_vs,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [31:0]        pix_data,
    output logic               out_valid,
    output logic               out_hs,
    output logic               out_vs,
    output logic [RGB_W-1:0]   out_rgb
);

    logic              layer_en, pal_mode, opaque;
    logic [RGB_W-1:0]  bg_color;
    logic [CH_W-1:0]   const_alpha;
    logic [2:0]        blend_code;
    span_t             win_x, win_y;
    logic              pal_we;
    logic [PAL_AW-1:0] pal_waddr;
    logic [RGB_W-1:0]  pal_wdata, pal_q;

    ovl_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .layer_en(layer_en), .pal_mode(pal_mode), .opaque(opaque),
        .bg_color(bg_color), .const_alpha(const_alpha), .blend_code(blend_code),
        .win_x(win_x), .win_y(win_y),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata)
    );

    ovl_palette #(.DEPTH(PAL_DEPTH), .DW(RGB_W)) u_pal (
        .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
        .re(pix_valid), .raddr(pix_data[PAL_AW-1:0]), .rdata(pal_q)
    );

    // inclusive test of one coordinate against one span
    function automatic logic in_span(input logic [COORD_W-1:0] c, input span_t s);
        return s.nonempty && (c >= s.first) && ({1'b0, c} <= s.last);
    endfunction

    logic            hit_d;
    logic [CH_W-1:0] pix_alpha, f1_d;

    // stage-1 decisions: window hit, effective alpha, layer weight
    always_comb begin
        hit_d     = layer_en && in_span(pix_x, win_x) && in_span(pix_y, win_y);
        pix_alpha = (pal_mode || opaque) ? '1 : pix_data[31:24];
        if (blend_code == BLEND_PIX_X_CONST)
            f1_d = div255(ACC_W'(pix_alpha) * ACC_W'(const_alpha) + ACC_W'(127));
        else
            f1_d = const_alpha;
    end

    logic             s1_valid, s1_hs, s1_vs, s1_hit, s1_pal;
    logic [RGB_W-1:0] s1_rgb, s1_bg, s1_layer;
    logic [CH_W-1:0]  s1_f1;

    // stage-1 register: pixel and the settings it is blended with
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hs    <= 1'b0;
            s1_vs    <= 1'b0;
            s1_hit   <= 1'b0;
            s1_pal   <= 1'b0;
            s1_rgb   <= '0;
            s1_bg    <= '0;
            s1_f1    <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_hs    <= pix_hs;
            s1_vs    <= pix_vs;
            s1_hit   <= hit_d;
            s1_pal   <= pal_mode;
            s1_rgb   <= pix_data[RGB_W-1:0];
            s1_bg    <= bg_color;
            s1_f1    <= f1_d;
        end
    end

    // pick palette colour or direct colour for the layer
    assign s1_layer = s1_pal ? pal_q : s1_rgb;

    ovl_mixer u_mix (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_hs(s1_hs), .s1_vs(s1_vs), .s1_hit(s1_hit),
        .s1_layer(s1_layer), .s1_bg(s1_bg), .s1_f1(s1_f1),
        .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
    );

endmodule

// File: rtl/ovl_blend_chk.sv
// Property checker for the overlay blender, bound to the top module.
// Relates outputs to inputs and configuration two cycles earlier.
module ovl_blend_chk
    import ovl_blend_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_hs,
    input logic             pix_vs,
    input logic             layer_en,
    input logic [RGB_W-1:0] bg_color,
    input logic [CH_W-1:0]  const_alpha,
    input logic             out_valid,
    input logic             out_hs,
    input logic             out_vs,
    input logic [RGB_W-1:0] out_rgb
);

    logic [1:0] seen;

    // count edges since reset, saturating, to gate history lookups
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (seen != 2'd3)
            seen <= seen + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_valid == $past(pix_valid, 2)));

    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_hs == $past(pix_hs, 2) && out_vs == $past(pix_vs, 2)));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0));

    assert_disabled_bg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && out_valid && !$past(layer_en, 2)) |-> (out_rgb == $past(bg_color, 2)));

    assert_zero_alpha_bg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen == 2'd3) && out_valid && ($past(const_alpha, 2) == '0)) |-> (out_rgb == $past(bg_color, 2)));

endmodule

bind ovl_blend_top ovl_blend_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .layer_en(layer_en), .bg_color(bg_color), .const_alpha(const_alpha),
    .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
);

// File: tb/ovl_blend_top_tb_top.sv
// Scoreboard bench: the driver pushes expected pixels, the monitor pops and compares.
module ovl_blend_top_tb_top;
    import ovl_blend_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        pix_valid, pix_hs, pix_vs;
    logic [15:0] pix_x, pix_y;
    logic [31:0] pix_data;
    logic        out_valid, out_hs, out_vs;
    logic [23:0] out_rgb;

    always #4 clk = ~clk;

    ovl_blend_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pix_valid(pix_valid), .pix_hs(pix_hs), .pix_vs(pix_vs),
        .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data),
        .out_valid(out_valid), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
    );

    typedef struct {
        logic [23:0] rgb;
        logic        hs;
        logic        vs;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   mon_on = 0;
    bit   done   = 0;

    // shadow of the configuration as the requirements define it
    bit          sh_en, sh_pal, sh_opq;
    logic [23:0] sh_bg;
    int          sh_ca, sh_code;
    int          wx0, wxw, wy0, wyw;
    logic [23:0] pal_sh [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(int x, int y, logic [31:0] d);
        int pa, f1, l, b;
        logic [23:0] lay, r;
        bit hit;
        hit = sh_en && wxw != 0 && wyw != 0 && x >= wx0 && x <= wx0 + wxw - 1
              && y >= wy0 && y <= wy0 + wyw - 1;
        if (!hit) return sh_bg;
        lay = sh_pal ? pal_sh[d[7:0]] : d[23:0];
        pa  = (sh_pal || sh_opq) ? 255 : int'(d[31:24]);
        f1  = (sh_code == 7) ? (pa * sh_ca + 127) / 255 : sh_ca;
        for (int c = 0; c < 3; c++) begin
            l = int'(lay[c*8 +: 8]);
            b = int'(sh_bg[c*8 +: 8]);
            r[c*8 +: 8] = 8'((l * f1 + b * (255 - f1) + 127) / 255);
        end
        return r;
    endfunction

    function automatic void apply_wr(logic [2:0] sel, logic [31:0] wd);
        case (sel)
            3'd0: begin sh_en = wd[0]; sh_pal = wd[4]; sh_opq = wd[8]; end
            3'd1: sh_bg = wd[23:0];
            3'd2: sh_ca = int'(wd[7:0]);
            3'd3: sh_code = int'(wd[2:0]);
            3'd4: begin wx0 = int'(wd[15:0]); wxw = int'(wd[31:16]); end
            3'd5: begin wy0 = int'(wd[15:0]); wyw = int'(wd[31:16]); end
            3'd6: pal_sh[wd[31:24]] = wd[23:0];
            default: ;
        endcase
    endfunction

    // driver: one cycle of pixel and/or configuration stimulus
    task automatic drive(bit pv, int x, int y, logic [31:0] d, bit hs, bit vs,
                         bit wr, logic [2:0] sel, logic [31:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        pix_valid = pv; pix_x = 16'(x); pix_y = 16'(y); pix_data = d;
        pix_hs = hs; pix_vs = vs;
        cfg_we = wr; cfg_sel = sel; cfg_wdata = wd;
        if (pv) begin
            e.rgb = model(x, y, d); e.hs = hs; e.vs = vs; e.cyc = cyc; e.tag = tag;
            q.push_back(e);
        end
        if (wr) apply_wr(sel, wd);
    endtask

    task automatic px(int x, int y, logic [31:0] d, string tag);
        drive(1, x, y, d, 0, 0, 0, 3'd0, 32'd0, tag);
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] wd);
        drive(0, 0, 0, 32'd0, 0, 0, 1, sel, wd, "");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 32'd0, 0, 0, 0, 3'd0, 32'd0, "");
    endtask

    // monitor: pop and compare each valid output, check idle outputs
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(0, "R1 unexpected output", 32'(out_rgb), 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_rgb == e.rgb, e.tag, 32'(out_rgb), 32'(e.rgb));
                    check(out_hs == e.hs && out_vs == e.vs, "R1 side-band",
                          {30'd0, out_hs, out_vs}, {30'd0, e.hs, e.vs});
                    check(cyc == e.cyc + 2, "R1 latency", 32'(cyc), 32'(e.cyc + 2));
                end
            end else begin
                check(out_rgb == 24'd0, "R2 idle output", 32'(out_rgb), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        sh_en = 0; sh_pal = 0; sh_opq = 0; sh_bg = 24'h0; sh_ca = 255; sh_code = 7;
        wx0 = 0; wxw = 0; wy0 = 0; wyw = 0;
        rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        pix_valid = 0; pix_hs = 0; pix_vs = 0; pix_x = 0; pix_y = 0; pix_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_rgb == 24'd0, "R2 reset state",
              {7'd0, out_valid, out_rgb}, 32'd0);
        mon_on = 1;

        // R5: background resets to black; R4: disabled layer shows background
        px(3, 3, 32'hFF_AB_CD_EF, "R5 reset black");
        idle(2);
        wr(3'd1, 32'h0012_3456);
        px(3, 3, 32'hFF_AB_CD_EF, "R4 disabled shows background");
        // R3: window x 10..14, y 20..22
        wr(3'd4, {16'd5, 16'd10});
        wr(3'd5, {16'd3, 16'd20});
        wr(3'd0, 32'h1);
        px(10, 20, 32'hFF_AA_BB_CC, "R12 reset alpha and code give opaque layer");
        px(14, 22, 32'hFF_11_22_33, "R3 inclusive corner");
        px(9, 20, 32'hFF_11_22_33, "R3 left of window");
        px(15, 20, 32'hFF_11_22_33, "R3 right of window");
        px(12, 19, 32'hFF_11_22_33, "R3 above window");
        px(12, 23, 32'hFF_11_22_33, "R3 below window");
        // R6: pixel alpha times constant alpha
        px(11, 21, 32'h80_FF_00_80, "R6 half pixel alpha");
        wr(3'd2, 32'h40);
        px(11, 21, 32'h80_FF_00_80, "R6 pixel and constant alpha");
        // R7: constant alpha only
        wr(3'd3, 32'h5);
        px(12, 21, 32'h00_F0_0F_77, "R7 pixel alpha ignored");
        wr(3'd2, 32'h0);
        px(12, 21, 32'hFF_F0_0F_77, "R7 zero constant alpha");
        // R10: alpha-less format with code 7
        wr(3'd3, 32'h7);
        wr(3'd2, 32'hFF);
        wr(3'd0, 32'h101);
        px(13, 22, 32'h00_5A_A5_3C, "R10 alpha treated opaque");
        wr(3'd2, 32'hA0);
        px(13, 22, 32'h00_5A_A5_3C, "R10 alpha-less with constant alpha");
        // R9 and R8: palette load and lookup
        wr(3'd6, 32'h03_C0_FF_EE);
        wr(3'd6, 32'hC8_01_02_03);
        wr(3'd0, 32'h11);
        px(10, 20, 32'h00_00_00_03, "R8 palette lookup entry 3");
        wr(3'd2, 32'hFF);
        px(14, 20, 32'h00_FF_FF_C8, "R9 palette entry 200");
        // R11: lookup and write of one entry in the same cycle
        wr(3'd6, 32'h05_AA_AA_AA);
        drive(1, 12, 21, 32'h0000_0005, 0, 0, 1, 3'd6, 32'h05_55_55_55, "R11 old entry on collision");
        px(12, 21, 32'h0000_0005, "R11 new entry after collision");
        // R1: back-to-back stream with side-band activity
        wr(3'd0, 32'h1);
        wr(3'd2, 32'hC0);
        for (int i = 0; i < 8; i++)
            drive(1, 8 + i, 21, {8'(i * 32), 8'(i * 29), 8'(200 - i * 7), 8'(i * 13)},
                  i[0], i == 0, 0, 3'd0, 32'd0, "R1 stream pixel");
        // R12: configuration change while pixels are in flight
        px(12, 21, 32'hFF_10_20_30, "R12 in-flight pixel keeps old setting");
        wr(3'd1, 32'h00FF_FFFF);
        px(12, 21, 32'hFF_10_20_30, "R12 new background next pixel");
        // R3: zero width window is empty
        wr(3'd4, {16'd0, 16'd0});
        px(0, 21, 32'hFF_10_20_30, "R3 zero width empty");
        idle(6);
        check(q.size() == 0, "R1 all results delivered", 32'(q.size()), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule